// File: doc/BRIEF.md
# Tuner Synthesizer Serial Command Interface

This block is the two-wire (I2C) target-side command front end of a tuning frequency synthesizer. It oversamples the bus clock and data lines with the system clock, finds START and STOP conditions, and compares the address byte against a 7-bit device address. The two lowest address bits come from a hardware select input, so up to four synthesizers can share one bus.

In a write transfer each data byte is sorted by its position in a group. A group begins with a byte whose most significant bit selects its kind. A frequency group is two bytes that together set a 15-bit divider ratio, and the ratio changes only when the pair is complete. A control group is a control byte followed by a band-switch port byte, and each of the two takes effect at the end of its own byte. Any number of groups can follow one address byte until STOP. An interrupted transfer keeps everything already committed.

In a read transfer the block returns a status byte that holds a power-on flag and an external lock indication.

Top module: `tuner_synth_cmd`

## Requirements
- R1: After reset the divider ratio is 0, the charge-pump current select is 0, the test mode is 000, the reference select is 00 (ratio 64), the charge-pump output is enabled (off bit 0), the port byte is 0x00, and SDA is not driven.
- R2: The address byte is {5'b11000, hw_sel[1:0], rw}. On a match the block pulls SDA low in the ninth clock. On a mismatch it does not acknowledge, and every byte up to the next START or STOP leaves all registers unchanged.
- R3: In a write transfer every data byte is acknowledged with SDA low, and the block begins driving SDA only while SCL is low.
- R4: A group-leading byte with bit 7 = 0 is the high frequency byte, and its bits [6:0] become divider bits [14:8]. The next byte supplies bits [7:0]. div_ratio keeps its old value until that second byte completes.
- R5: A group-leading byte with bit 7 = 1 is the control byte, with bit 6 as the charge-pump current select, [5:3] as the test mode, [2:1] as the reference select and bit 0 as the charge-pump off bit. It commits at the end of its byte. The byte after it is the port byte and commits at the end of its own byte. After the port byte, decoding returns to group start.
- R6: ref_ratio follows ref_sel: 00 gives 64, 01 gives 80, 10 gives 24, 11 gives 28.
- R7: Several frequency and control groups can follow one address byte without re-addressing. Each committed value is visible before the next group starts.
- R8: A STOP or a repeated START discards a half-received frequency pair, keeps all committed values, and restarts decoding at group start.
- R9: A read returns {por, lock_i, 6'b000000}. por is 1 after reset and becomes 0 once a status byte has been fully sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| hw_sel | input | 2 | Hardware select for the two low address bits |
| lock_i | input | 1 | Lock indication reported in the status byte |
| sda_oe | output | 1 | 1 pulls the data line low |
| div_ratio | output | 15 | Committed divider ratio |
| cp_cur_hi | output | 1 | Charge-pump current select |
| test_mode | output | 3 | Test-mode select |
| ref_sel | output | 2 | Reference-divider select code |
| ref_ratio | output | 7 | Decoded reference divide ratio |
| cp_out_off | output | 1 | 1 turns the charge-pump output off |
| band_port | output | 8 | Committed band-switch port byte |

## Verification
A group-position counter that is out of step shows at the ports as a byte landing in the wrong register. For example, a port value appears in the divider, or a control byte is taken as a frequency byte. This shows on the first transfer after the fault and is visible right after that byte's acknowledge. A shadow that is not cleared or a commit that fires early shows as div_ratio moving after the first frequency byte instead of after the second. A stuck power-on flag shows on the second status read. The bench compares every output after each acknowledge of interest and after each transaction against a model written from the requirements.

// File: rtl/tuner_synth_cmd_pkg.sv
package tuner_synth_cmd_pkg;
   localparam int DIV_W   = 15;
   localparam int BYTE_W  = 8;
   localparam int HW_W    = 2;
   localparam int ADDR_W  = 7;
   localparam int BASE_W  = ADDR_W - HW_W;
   localparam int RATIO_W = 7;

   typedef enum logic [2:0] {
      LS_IDLE, LS_ADDR, LS_ADDR_ACK, LS_WDATA, LS_WACK, LS_RDATA, LS_RACK, LS_SKIP
   } link_state_t;

   typedef enum logic [1:0] {GP_HEAD, GP_FREQ_LO, GP_PORT} group_pos_t;

   typedef struct packed {
      logic       cp_hi;
      logic [2:0] test;
      logic [1:0] rsel;
      logic       cp_off;
   } ctrl_t;

   function automatic logic [RATIO_W-1:0] decode_ratio(input logic [1:0] code);
      case (code)
         2'b00:   return RATIO_W'(64);
         2'b01:   return RATIO_W'(80);
         2'b10:   return RATIO_W'(24);
         default: return RATIO_W'(28);
      endcase
   endfunction
endpackage

// File: rtl/tcmd_bus_sampler.sv
module tcmd_bus_sampler #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_q,
   output logic sda_q,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   localparam int MSB = SYNC_STAGES - 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [MSB:0] scl_pipe, sda_pipe;
   logic         scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_d    <= 1'b1;
         sda_d    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[MSB-1:0], scl_i};
         sda_pipe <= {sda_pipe[MSB-1:0], sda_i};
         scl_d    <= scl_pipe[MSB];
         sda_d    <= sda_pipe[MSB];
      end
   end

   assign scl_q     = scl_pipe[MSB];
   assign sda_q     = sda_pipe[MSB];
   assign scl_rise  = scl_q & ~scl_d;
   assign scl_fall  = ~scl_q & scl_d;
   assign start_det = scl_q & scl_d & sda_d & ~sda_q;
   assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/tcmd_link.sv
module tcmd_link
   import tuner_synth_cmd_pkg::*;
#(
   parameter logic [BASE_W-1:0] BASE_ADDR = 5'b11000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_q,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [HW_W-1:0]   hw_sel,
   input  logic [BYTE_W-1:0] status,
   output logic              sda_oe,
   output logic              byte_stb,
   output logic [BYTE_W-1:0] byte_q,
   output logic              frame_clr,
   output logic              rd_done,
   output link_state_t       link_st
);
   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

   logic [BYTE_W-1:0] sh;
   logic [CNT_W-1:0]  cnt;
   logic              rw, mack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         link_st   <= LS_IDLE;
         sh        <= '0;
         cnt       <= '0;
         rw        <= 1'b0;
         mack      <= 1'b0;
         sda_oe    <= 1'b0;
         byte_stb  <= 1'b0;
         byte_q    <= '0;
         frame_clr <= 1'b0;
         rd_done   <= 1'b0;
      end else begin
         byte_stb  <= 1'b0;
         frame_clr <= 1'b0;
         rd_done   <= 1'b0;
         if (start_det) begin
            link_st   <= LS_ADDR;
            cnt       <= '0;
            sda_oe    <= 1'b0;
            frame_clr <= 1'b1;
         end else if (stop_det) begin
            link_st   <= LS_IDLE;
            sda_oe    <= 1'b0;
            frame_clr <= 1'b1;
         end else begin
            case (link_st)
               LS_ADDR: begin
                  if (scl_rise) begin
                     sh  <= {sh[BYTE_W-2:0], sda_q};
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall && cnt == LAST_BIT) begin
                     cnt <= '0;
                     if (sh[BYTE_W-1:1] == {BASE_ADDR, hw_sel}) begin
                        link_st <= LS_ADDR_ACK;
                        sda_oe  <= 1'b1;
                        rw      <= sh[0];
                     end else begin
                        link_st <= LS_SKIP;
                     end
                  end
               end
               LS_ADDR_ACK: begin
                  if (scl_fall) begin
                     if (rw) begin
                        link_st <= LS_RDATA;
                        sh      <= status;
                        sda_oe  <= ~status[BYTE_W-1];
                     end else begin
                        link_st <= LS_WDATA;
                        sda_oe  <= 1'b0;
                     end
                  end
               end
               LS_WDATA: begin
                  if (scl_rise) begin
                     sh  <= {sh[BYTE_W-2:0], sda_q};
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall && cnt == LAST_BIT) begin
                     cnt      <= '0;
                     byte_stb <= 1'b1;
                     byte_q   <= sh;
                     sda_oe   <= 1'b1;
                     link_st  <= LS_WACK;
                  end
               end
               LS_WACK: begin
                  if (scl_fall) begin
                     sda_oe  <= 1'b0;
                     link_st <= LS_WDATA;
                  end
               end
               LS_RDATA: begin
                  if (scl_rise) begin
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall) begin
                     if (cnt == LAST_BIT) begin
                        cnt     <= '0;
                        sda_oe  <= 1'b0;
                        rd_done <= 1'b1;
                        link_st <= LS_RACK;
                     end else begin
                        sh     <= {sh[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~sh[BYTE_W-2];
                     end
                  end
               end
               LS_RACK: begin
                  if (scl_rise) begin
                     mack <= ~sda_q;
                  end else if (scl_fall) begin
                     if (mack) begin
                        link_st <= LS_RDATA;
                        sh      <= status;
                        sda_oe  <= ~status[BYTE_W-1];
                     end else begin
                        link_st <= LS_SKIP;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/tcmd_reg_bank.sv
module tcmd_reg_bank
   import tuner_synth_cmd_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_stb,
   input  logic [BYTE_W-1:0] byte_q,
   input  logic              frame_clr,
   input  logic              rd_done,
   input  logic              lock_i,
   output logic [DIV_W-1:0]  div_ratio,
   output ctrl_t             ctrl_q,
   output logic [BYTE_W-1:0] band_port,
   output logic [BYTE_W-1:0] status,
   output group_pos_t        grp_pos
);
   localparam int HI_W = DIV_W - BYTE_W;

   logic [HI_W-1:0] shadow_hi;
   logic            por_flag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_ratio <= '0;
         ctrl_q    <= '0;
         band_port <= '0;
         shadow_hi <= '0;
         grp_pos   <= GP_HEAD;
         por_flag  <= 1'b1;
      end else begin
         if (rd_done) por_flag <= 1'b0;
         if (frame_clr) begin
            grp_pos   <= GP_HEAD;
            shadow_hi <= '0;
         end else if (byte_stb) begin
            case (grp_pos)
               GP_HEAD: begin
                  if (!byte_q[BYTE_W-1]) begin
                     shadow_hi <= byte_q[HI_W-1:0];
                     grp_pos   <= GP_FREQ_LO;
                  end else begin
                     ctrl_q  <= ctrl_t'(byte_q[BYTE_W-2:0]);
                     grp_pos <= GP_PORT;
                  end
               end
               GP_FREQ_LO: begin
                  div_ratio <= {shadow_hi, byte_q};
                  grp_pos   <= GP_HEAD;
               end
               default: begin
                  band_port <= byte_q;
                  grp_pos   <= GP_HEAD;
               end
            endcase
         end
      end
   end

   assign status = {por_flag, lock_i, {(BYTE_W-2){1'b0}}};
endmodule

// File: rtl/tuner_synth_cmd.sv
module tuner_synth_cmd
   import tuner_synth_cmd_pkg::*;
#(
   parameter logic [4:0] BASE_ADDR   = 5'b11000,
   parameter int         SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         scl_i,
   input  logic         sda_i,
   input  logic [1:0]   hw_sel,
   input  logic         lock_i,
   output logic         sda_oe,
   output logic [14:0]  div_ratio,
   output logic         cp_cur_hi,
   output logic [2:0]   test_mode,
   output logic [1:0]   ref_sel,
   output logic [6:0]   ref_ratio,
   output logic         cp_out_off,
   output logic [7:0]   band_port
);
   logic              scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;
   logic              byte_stb, frame_clr, rd_done;
   logic [BYTE_W-1:0] byte_q, status;
   link_state_t       link_st;
   group_pos_t        grp_pos;
   ctrl_t             ctrl_q;

   tcmd_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   tcmd_link #(.BASE_ADDR(BASE_ADDR)) u_link (
      .clk(clk), .rst_n(rst_n), .sda_q(sda_q), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
      .hw_sel(hw_sel), .status(status), .sda_oe(sda_oe), .byte_stb(byte_stb),
      .byte_q(byte_q), .frame_clr(frame_clr), .rd_done(rd_done), .link_st(link_st)
   );

   tcmd_reg_bank u_regs (
      .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .byte_q(byte_q),
      .frame_clr(frame_clr), .rd_done(rd_done), .lock_i(lock_i),
      .div_ratio(div_ratio), .ctrl_q(ctrl_q), .band_port(band_port),
      .status(status), .grp_pos(grp_pos)
   );

   assign cp_cur_hi  = ctrl_q.cp_hi;
   assign test_mode  = ctrl_q.test;
   assign ref_sel    = ctrl_q.rsel;
   assign cp_out_off = ctrl_q.cp_off;
   assign ref_ratio  = decode_ratio(ctrl_q.rsel);
endmodule

// File: rtl/tuner_synth_cmd_chk.sv
module tuner_synth_cmd_chk
   import tuner_synth_cmd_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        scl_q,
   input logic        sda_oe,
   input logic        byte_stb,
   input logic        frame_clr,
   input logic        rd_done,
   input logic [7:0]  status,
   input group_pos_t  grp_pos,
   input link_state_t link_st,
   input logic [14:0] div_ratio,
   input logic [7:0]  band_port,
   input logic [6:0]  ctrl_bits
);
   AST_DIV_ONLY_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(byte_stb) |-> $stable(div_ratio)); // R4
   AST_PORT_ONLY_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(byte_stb) |-> $stable(band_port)); // R5
   AST_CTRL_ONLY_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(byte_stb) |-> $stable(ctrl_bits)); // R5
   AST_DRIVE_STARTS_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe && !$past(sda_oe)) |-> !$past(scl_q)); // R3
   AST_NO_DRIVE_WHEN_UNADDRESSED: assert property (@(posedge clk) disable iff (!rst_n)
      (link_st == LS_SKIP || link_st == LS_IDLE || link_st == LS_ADDR) |-> !sda_oe); // R2
   AST_FRAME_RESTARTS_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
      frame_clr |=> (grp_pos == GP_HEAD)); // R8
   AST_POR_CLEARS_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |=> !status[7]); // R9
endmodule

bind tuner_synth_cmd tuner_synth_cmd_chk u_chk (
   .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .sda_oe(sda_oe), .byte_stb(byte_stb),
   .frame_clr(frame_clr), .rd_done(rd_done), .status(status), .grp_pos(grp_pos),
   .link_st(link_st), .div_ratio(div_ratio), .band_port(band_port),
   .ctrl_bits({cp_cur_hi, test_mode, ref_sel, cp_out_off})
);

// File: tb/tb_tuner_synth_cmd.sv
module tb_tuner_synth_cmd;
   localparam int Q = 6;
   localparam logic [4:0] BASE = 5'b11000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1, lock_i = 1'b0;
   logic [1:0] hw_sel = 2'b10;
   logic sda_oe, sda_bus;
   logic [14:0] div_ratio;
   logic cp_cur_hi, cp_out_off;
   logic [2:0] test_mode;
   logic [1:0] ref_sel;
   logic [6:0] ref_ratio;
   logic [7:0] band_port;

   int checks = 0, errors = 0;
   bit done = 0;

   logic [14:0] e_div = '0;
   logic [6:0]  e_ctrl = '0;
   logic [7:0]  e_port = '0;
   logic [6:0]  e_hi = '0;
   int          e_pos = 0;

   always #2.5 clk = ~clk;
   assign sda_bus = sda_m & ~sda_oe;

   tuner_synth_cmd dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .hw_sel(hw_sel),
      .lock_i(lock_i), .sda_oe(sda_oe), .div_ratio(div_ratio), .cp_cur_hi(cp_cur_hi),
      .test_mode(test_mode), .ref_sel(ref_sel), .ref_ratio(ref_ratio),
      .cp_out_off(cp_out_off), .band_port(band_port)
   );

   function automatic logic [6:0] exp_ratio(input logic [1:0] c);
      case (c)
         2'b00: return 7'd64;
         2'b01: return 7'd80;
         2'b10: return 7'd24;
         default: return 7'd28;
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // model of the requirements R4, R5, R8
   task automatic model_byte(input logic [7:0] b);
      case (e_pos)
         0: if (!b[7]) begin e_hi = b[6:0]; e_pos = 1; end
            else begin e_ctrl = b[6:0]; e_pos = 2; end
         1: begin e_div = {e_hi, b}; e_pos = 0; end
         default: begin e_port = b; e_pos = 0; end
      endcase
   endtask

   task automatic chk_all(input string req);
      chk({req, " div"}, 32'(div_ratio), 32'(e_div));
      chk({req, " ctrl"}, 32'({cp_cur_hi, test_mode, ref_sel, cp_out_off}), 32'(e_ctrl));
      chk({req, " port"}, 32'(band_port), 32'(e_port));
      chk({req, " R6 ratio"}, 32'(ref_ratio), 32'(exp_ratio(e_ctrl[2:1])));
   endtask

   task automatic i2c_start;
      sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
      e_pos = 0;
   endtask

   task automatic i2c_stop;
      sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(Q);
      e_pos = 0;
   endtask

   task automatic wr_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(Q);
      end
      sda_m = 1; tick(Q); scl_m = 1; tick(Q); ack = ~sda_bus; tick(Q); scl_m = 0; tick(Q);
   endtask

   task automatic rd_byte(input logic mack, output logic [7:0] b);
      sda_m = 1;
      for (int i = 7; i >= 0; i--) begin
         tick(Q); scl_m = 1; tick(Q); b[i] = sda_bus; tick(Q); scl_m = 0; tick(Q);
      end
      sda_m = ~mack; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(Q); sda_m = 1;
   endtask

   task automatic wr_data(input logic [7:0] b, input string req);
      logic a;
      wr_byte(b, a);
      chk({req, " R3 data ack"}, 32'(a), 32'd1);
      model_byte(b);
   endtask

   task automatic addr_w(input logic [1:0] hw, input string req);
      logic a;
      wr_byte({BASE, hw, 1'b0}, a);
      chk({req, " R2 addr ack"}, 32'(a), 32'(hw == hw_sel));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] rb;
      logic a;
      void'($urandom(32'h5EED1234));
      tick(4); rst_n = 1; tick(4);

      // R1 reset defaults
      chk_all("R1");
      chk("R1 sda released", 32'(sda_oe), 32'd0);

      // R4 frequency pair, held until second byte
      i2c_start(); addr_w(hw_sel, "R2");
      wr_data(8'h35, "R4");
      chk("R4 div held after first byte", 32'(div_ratio), 32'd0);
      wr_data(8'hA7, "R4");
      chk("R4 div after pair", 32'(div_ratio), 32'h35A7);
      i2c_stop(); chk_all("R4");

      // R5 control then port; R6 all ratios
      for (int c = 0; c < 4; c++) begin
         i2c_start(); addr_w(hw_sel, "R5");
         wr_data({1'b1, 1'b1, 3'(c + 2), 2'(c), 1'(c)}, "R5");
         chk("R5 ctrl committed at own byte",
             32'({cp_cur_hi, test_mode, ref_sel, cp_out_off}), 32'(e_ctrl));
         chk("R6 ratio", 32'(ref_ratio), 32'(exp_ratio(2'(c))));
         wr_data(8'h80 | 8'(c * 17), "R5");
         chk("R5 port", 32'(band_port), 32'(e_port));
         i2c_stop(); chk_all("R5");
      end

      // R7 sweep within one transaction
      i2c_start(); addr_w(hw_sel, "R7");
      for (int k = 0; k < 3; k++) begin
         wr_data(8'h10 + 8'(k), "R7"); wr_data(8'h40 + 8'(k * 3), "R7");
         chk("R7 sweep div", 32'(div_ratio), 32'(e_div));
      end
      wr_data(8'hC2, "R7"); wr_data(8'h5A, "R7");
      wr_data(8'h01, "R7"); wr_data(8'h02, "R7");
      i2c_stop(); chk_all("R7");

      // R8 abort by STOP with half pair, then restart decoding
      i2c_start(); addr_w(hw_sel, "R8");
      wr_data(8'h7F, "R8");
      i2c_stop();
      chk("R8 half pair discarded", 32'(div_ratio), 32'(e_div));
      i2c_start(); addr_w(hw_sel, "R8");
      wr_data(8'h01, "R8");
      i2c_start(); addr_w(hw_sel, "R8");
      wr_data(8'hE0, "R8");
      chk("R8 restart is control", 32'({cp_cur_hi, test_mode, ref_sel, cp_out_off}), 32'(7'h60));
      wr_data(8'h3C, "R8");
      i2c_stop(); chk_all("R8");

      // R2 wrong address ignored
      i2c_start(); addr_w(hw_sel ^ 2'b01, "R2");
      wr_byte(8'h12, a); chk("R2 no data ack", 32'(a), 32'd0);
      wr_byte(8'h34, a);
      i2c_stop(); chk_all("R2 ignored");

      // R9 status reads
      lock_i = 1;
      i2c_start(); wr_byte({BASE, hw_sel, 1'b1}, a);
      chk("R9 read addr ack", 32'(a), 32'd1);
      rd_byte(1'b1, rb); chk("R9 first status", 32'(rb), 32'hC0);
      rd_byte(1'b0, rb); chk("R9 second status", 32'(rb), 32'h40);
      i2c_stop();
      lock_i = 0;
      i2c_start(); wr_byte({BASE, hw_sel, 1'b1}, a);
      rd_byte(1'b0, rb); chk("R9 por stays clear", 32'(rb), 32'h00);
      i2c_stop();

      // random transactions
      for (int t = 0; t < 30; t++) begin
         logic [1:0] hw;
         int n;
         hw = ($urandom % 5 == 0) ? ($urandom & 2'b11) : hw_sel;
         n = 1 + ($urandom % 6);
         i2c_start(); addr_w(hw, "R2 rand");
         for (int j = 0; j < n; j++) begin
            logic [7:0] b;
            b = 8'($urandom);
            if (hw == hw_sel) wr_data(b, "R7 rand");
            else wr_byte(b, a);
         end
         i2c_stop(); chk_all("R8 rand");
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule